// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block sends one data word per serial frame. A CPU loads a word into a parallel holding register. When a frame begins, the word moves into the transmit datapath and goes out on a serial data line, one bit per serial clock. A shared timing source supplies the serial clock, as a one-cycle enable on the system clock `clk`, and the frame sync. The sync can be a pulse one bit long, or a level that covers the data word.

The shift direction, the word length and the value for the output flag pins are control inputs. They are captured at the start of each frame and do not change until the next frame. The data line carries an output-enable so that a pad can put it in high impedance between frames. The block reports an empty status for the holding register, a level interrupt request, and a sticky underrun error. Underrun is raised when a frame begins before any new word has been written; in that case the previous word is sent again.

Top module: `sft_tx_top`

## Requirements
- R1: At a serial tick where the frame sync is high and a frame may start, with `tx_en`=1, the holding word is transferred and `empty` becomes 1. `irq` equals `empty & irq_en` at all times.
- R2: Words are held left-aligned in a 24-bit register. `wlen` 0/1/2/3 selects 8/12/16/24 bits. With `lsb_first`=0, bits leave from bit 23 downward. With `lsb_first`=1, they leave from bit 24-L upward, where L is the word length.
- R3: `sd_oe` is 1 only while data bits of a transmitted frame are on `sd_out`. It is 0 in gaps, while waiting for the first bit, and when the transmitter is disabled.
- R4: With `fs_bit_mode`=0, the first bit appears after the tick that starts the frame. Each following tick presents the next bit. `sd_oe` falls after the tick that follows the last bit, unless a sync on that tick starts a new frame at once.
- R5: With `fs_bit_mode`=1, `sd_out` stays disabled after the tick carrying the sync pulse. The first bit appears after the next tick.
- R6: A frame sync seen on any tick of a frame other than the tick that ends its last bit is ignored. The frame length and the transfer count are unchanged.
- R7: `flag_out` takes `flag_val` at every frame start, whatever `tx_en` is. It holds that value for the whole frame and through the gap that follows. `flag_out` is always driven.
- R8: A frame start with `tx_en`=1 and `empty`=1 sets `underrun` and sends the previously transmitted word again. A CPU write (`wr_en`) loads the holding register and clears both `empty` and `underrun`.
- R9: After reset: `empty`=1, `underrun`=0, `sd_oe`=0, `flag_out`=0.
- R10: A frame that starts with `tx_en`=0 drives no data and leaves the holding register and `empty` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_en | input | 1 | One-cycle serial clock tick |
| fsync | input | 1 | Frame sync, sampled on ticks |
| fs_bit_mode | input | 1 | 1: sync is a one-tick pulse before the data; 0: sync level is present with the first bit |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Interrupt enable |
| lsb_first | input | 1 | Shift direction select |
| wlen | input | 2 | Word length code |
| flag_val | input | FLAG_W | Value for the flag pins at next frame start |
| wr_en | input | 1 | CPU write strobe for holding register |
| wr_data | input | 24 | CPU write data, left-aligned |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for serial data pad |
| flag_out | output | FLAG_W | Frame-latched flag outputs |
| empty | output | 1 | Holding register empty |
| irq | output | 1 | Transmit interrupt request |
| underrun | output | 1 | Sticky underrun error |

## Verification
The assertions check the following on every cycle:
- the data enable is never on outside the shifting phase;
- every enabled frame start leaves the empty flag set, and an empty start raises underrun;
- the flags only move at a frame start;
- a sync that arrives in mid-frame neither reloads nor stalls the bit counter.

Only the bench's scenarios can show the following:
- the bit order for each length and direction, and the one-tick delay of the bit-pulse sync;
- the word that is sent again after an underrun;
- a back-to-back frame that keeps the line enabled;
- a disabled frame leaving the holding register intact.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int WORD_W = 24;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_WAIT,
        FS_SHIFT
    } fs_state_e;

    typedef enum logic [1:0] {
        WL_8  = 2'd0,
        WL_12 = 2'd1,
        WL_16 = 2'd2,
        WL_24 = 2'd3
    } wlen_e;

    typedef struct packed {
        wlen_e wlen;
        logic  lsb_first;
    } fmt_t;

    function automatic logic [CNT_W-1:0] word_bits(input wlen_e wl);
        case (wl)
            WL_8:    word_bits = CNT_W'(8);
            WL_12:   word_bits = CNT_W'(12);
            WL_16:   word_bits = CNT_W'(16);
            default: word_bits = CNT_W'(WORD_W);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] first_index(input fmt_t f);
        if (f.lsb_first)
            first_index = CNT_W'(WORD_W) - word_bits(f.wlen);
        else
            first_index = CNT_W'(WORD_W - 1);
    endfunction

    function automatic logic [CNT_W-1:0] step_index(input logic [CNT_W-1:0] idx,
                                                    input logic lsb);
        step_index = lsb ? idx + CNT_W'(1) : idx - CNT_W'(1);
    endfunction

endpackage

// File: rtl/sft_frame_ctl.sv
module sft_frame_ctl
    import sft_pkg::*;
#(
    parameter int FLAG_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              fsync,
    input  logic              bit_mode,
    input  fmt_t              fmt_in,
    input  logic [FLAG_W-1:0] flag_in,
    output logic              start,
    output logic              load_first,
    output logic              advance,
    output logic              stop,
    output fmt_t              fmt_cur,
    output logic [FLAG_W-1:0] flag_q,
    output logic              shifting
);

    fs_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    fmt_t             fmt_q;
    logic             can_start;

    assign can_start  = (st_q == FS_IDLE) || (st_q == FS_SHIFT && cnt_q == '0);
    assign start      = tick && fsync && can_start;
    assign fmt_cur    = start ? fmt_in : fmt_q;
    assign load_first = tick && ((start && !bit_mode) || (!start && st_q == FS_WAIT));
    assign advance    = tick && !start && st_q == FS_SHIFT && cnt_q != '0;
    assign stop       = tick && st_q == FS_SHIFT && cnt_q == '0 && !load_first;
    assign shifting   = (st_q == FS_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_IDLE;
            cnt_q  <= '0;
            fmt_q  <= '0;
            flag_q <= '0;
        end else if (tick) begin
            if (start) begin
                fmt_q  <= fmt_in;
                flag_q <= flag_in;
            end
            if (load_first) begin
                st_q  <= FS_SHIFT;
                cnt_q <= word_bits(fmt_cur.wlen) - CNT_W'(1);
            end else if (start) begin
                st_q <= FS_WAIT;
            end else if (advance) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (stop) begin
                st_q <= FS_IDLE;
            end
        end
    end

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(flag_q));

    // R6
    mid_sync_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && fsync && st_q == FS_SHIFT && cnt_q != '0)
            |=> (st_q == FS_SHIFT && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/sft_hold_buf.sv
module sft_hold_buf
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic              tx_en,
    output logic [WORD_W-1:0] hold_q,
    output logic              empty_q,
    output logic              underrun_q,
    output logic              take
);

    logic xfer;

    assign xfer = start && tx_en;
    assign take = xfer && !empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            empty_q    <= 1'b1;
            underrun_q <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q     <= wr_data;
                empty_q    <= 1'b0;
                underrun_q <= 1'b0;
            end else if (xfer) begin
                empty_q <= 1'b1;
                if (empty_q)
                    underrun_q <= 1'b1;
            end
        end
    end

    // R1
    empty_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !wr_en) |=> empty_q);

    // R8
    underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && empty_q && !wr_en) |=> underrun_q);

endmodule

// File: rtl/sft_bit_drv.sv
module sft_bit_drv
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tx_en,
    input  logic              take,
    input  logic [WORD_W-1:0] hold_word,
    input  fmt_t              fmt_cur,
    input  logic              load_first,
    input  logic              advance,
    input  logic              stop,
    output logic              sd_q,
    output logic              oe_q
);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  idx_q;
    logic              act_q;
    logic [WORD_W-1:0] word_nxt;
    logic              act_nxt;
    logic [CNT_W-1:0]  idx_first;
    logic [CNT_W-1:0]  idx_step;

    assign word_nxt  = take ? hold_word : word_q;
    assign act_nxt   = start ? tx_en : act_q;
    assign idx_first = first_index(fmt_cur);
    assign idx_step  = step_index(idx_q, fmt_cur.lsb_first);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            act_q  <= 1'b0;
            sd_q   <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            word_q <= word_nxt;
            act_q  <= act_nxt;
            if (load_first) begin
                idx_q <= idx_first;
                sd_q  <= act_nxt & word_nxt[idx_first];
                oe_q  <= act_nxt;
            end else if (advance) begin
                idx_q <= idx_step;
                sd_q  <= act_q & word_q[idx_step];
            end else if (stop || start) begin
                sd_q <= 1'b0;
                oe_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sft_tx_top.sv
module sft_tx_top
    import sft_pkg::*;
#(
    parameter int FLAG_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_en,
    input  logic              fsync,
    input  logic              fs_bit_mode,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic              lsb_first,
    input  logic [1:0]        wlen,
    input  logic [FLAG_W-1:0] flag_val,
    input  logic              wr_en,
    input  logic [23:0]       wr_data,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [FLAG_W-1:0] flag_out,
    output logic              empty,
    output logic              irq,
    output logic              underrun
);

    fmt_t              fmt_in;
    fmt_t              fmt_cur;
    logic              start;
    logic              load_first;
    logic              advance;
    logic              stop;
    logic              shifting;
    logic              take;
    logic [WORD_W-1:0] hold_word;

    assign fmt_in.wlen      = wlen_e'(wlen);
    assign fmt_in.lsb_first = lsb_first;

    sft_frame_ctl #(.FLAG_W(FLAG_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .tick      (sclk_en),
        .fsync     (fsync),
        .bit_mode  (fs_bit_mode),
        .fmt_in    (fmt_in),
        .flag_in   (flag_val),
        .start     (start),
        .load_first(load_first),
        .advance   (advance),
        .stop      (stop),
        .fmt_cur   (fmt_cur),
        .flag_q    (flag_out),
        .shifting  (shifting)
    );

    sft_hold_buf u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .start     (start),
        .tx_en     (tx_en),
        .hold_q    (hold_word),
        .empty_q   (empty),
        .underrun_q(underrun),
        .take      (take)
    );

    sft_bit_drv u_drv (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tx_en     (tx_en),
        .take      (take),
        .hold_word (hold_word),
        .fmt_cur   (fmt_cur),
        .load_first(load_first),
        .advance   (advance),
        .stop      (stop),
        .sd_q      (sd_out),
        .oe_q      (sd_oe)
    );

    assign irq = empty & irq_en;

    // R3
    oe_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> shifting);

endmodule

// File: tb/sft_tx_top_tb_top.sv
`timescale 1ns/1ps
module sft_tx_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_en = 1'b0;
    logic        fsync = 1'b0;
    logic        fs_bit_mode = 1'b0;
    logic        tx_en = 1'b1;
    logic        irq_en = 1'b0;
    logic        lsb_first = 1'b0;
    logic [1:0]  wlen = 2'd0;
    logic [1:0]  flag_val = 2'd0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic        sd_out, sd_oe, empty, irq, underrun;
    logic [1:0]  flag_out;

    int checks = 0;
    int errors = 0;
    logic s_sd, s_oe;

    always #10 clk = ~clk;

    sft_tx_top #(.FLAG_W(2)) dut_i (
        .clk(clk), .rst(rst), .sclk_en(sclk_en), .fsync(fsync),
        .fs_bit_mode(fs_bit_mode), .tx_en(tx_en), .irq_en(irq_en),
        .lsb_first(lsb_first), .wlen(wlen), .flag_val(flag_val),
        .wr_en(wr_en), .wr_data(wr_data), .sd_out(sd_out), .sd_oe(sd_oe),
        .flag_out(flag_out), .empty(empty), .irq(irq), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic fs);
        @(negedge clk);
        sclk_en = 1'b1;
        fsync   = fs;
        @(negedge clk);
        s_sd    = sd_out;
        s_oe    = sd_oe;
        sclk_en = 1'b0;
        fsync   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_word(input logic [23:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int len_of(input int code);
        case (code)
            0: return 8;
            1: return 12;
            2: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic exp_bit(input logic [23:0] w, input int l, input int k,
                                     input bit lsb);
        return lsb ? w[24 - l + k] : w[23 - k];
    endfunction

    // Word mode, 8-bit MSB-first frame; checks every bit against w
    task automatic frame8(input logic [23:0] w, input string req);
        tick(1'b1);
        chk(s_oe == 1'b1, req, s_oe, 1);
        chk(s_sd == w[23], req, s_sd, w[23]);
        for (int k = 1; k < 8; k++) begin
            tick(1'b0);
            chk(s_sd == w[23 - k] && s_oe, req, s_sd, w[23 - k]);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(empty == 1'b1, "R9 empty", empty, 1);
        chk(underrun == 1'b0, "R9 underrun", underrun, 0);
        chk(sd_oe == 1'b0, "R9 oe", sd_oe, 0);
        chk(flag_out == 2'd0, "R9 flags", flag_out, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);

        // Gap ticks keep the line disabled (R3)
        for (int g = 0; g < 3; g++) begin
            tick(1'b0);
            chk(s_oe == 1'b0, "R3 gap", s_oe, 0);
        end

        // Sweep: sync mode x direction x length
        for (int m = 0; m < 2; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int wl = 0; wl < 4; wl++) begin
                    automatic int          l   = len_of(wl);
                    automatic int          ci  = m * 8 + d * 4 + wl;
                    automatic logic [23:0] w   = 24'h5A3C96 ^ (24'(ci) * 24'h13579B);
                    automatic logic [1:0]  fv  = 2'(ci);
                    write_word(w);
                    chk(empty == 1'b0, "R8 write clears empty", empty, 0);
                    fs_bit_mode = m[0];
                    lsb_first   = d[0];
                    wlen        = 2'(wl);
                    irq_en      = d[0];
                    flag_val    = fv;
                    tick(1'b1);
                    chk(flag_out == fv, "R7 flag latch", flag_out, fv);
                    chk(empty == 1'b1, "R1 empty on transfer", empty, 1);
                    chk(irq == d[0], "R1 irq", irq, d);
                    flag_val = ~fv;
                    if (m == 0) begin
                        chk(s_oe == 1'b1, "R4 first bit oe", s_oe, 1);
                        chk(s_sd == exp_bit(w, l, 0, d[0]), "R2 bit0", s_sd,
                            exp_bit(w, l, 0, d[0]));
                        for (int k = 1; k < l; k++) begin
                            tick(1'b1); // held sync: R6 ignored mid-frame
                            chk(s_oe == 1'b1, "R6 oe held", s_oe, 1);
                            chk(s_sd == exp_bit(w, l, k, d[0]), "R2 bit", s_sd,
                                exp_bit(w, l, k, d[0]));
                        end
                    end else begin
                        chk(s_oe == 1'b0, "R5 wait tick", s_oe, 0);
                        for (int k = 0; k < l; k++) begin
                            tick(1'b0);
                            chk(s_oe == 1'b1, "R5 oe", s_oe, 1);
                            chk(s_sd == exp_bit(w, l, k, d[0]), "R2 bit", s_sd,
                                exp_bit(w, l, k, d[0]));
                        end
                    end
                    tick(1'b0);
                    chk(s_oe == 1'b0, "R4 end of frame", s_oe, 0);
                    chk(flag_out == fv, "R7 flag hold", flag_out, fv);
                    chk(underrun == 1'b0, "R8 no underrun", underrun, 0);
                end
            end
        end

        fs_bit_mode = 1'b0;
        lsb_first   = 1'b0;
        wlen        = 2'd0;
        irq_en      = 1'b1;

        // R8 underrun: resend previous word
        write_word(24'hC30000);
        frame8(24'hC30000, "R8 first frame");
        tick(1'b0);
        frame8(24'hC30000, "R8 resend");
        chk(underrun == 1'b1, "R8 underrun set", underrun, 1);
        chk(empty == 1'b1, "R8 empty", empty, 1);
        tick(1'b0);
        write_word(24'h3C0000);
        chk(underrun == 1'b0, "R8 write clears underrun", underrun, 0);

        // R10 disabled transmitter
        tx_en    = 1'b0;
        flag_val = 2'd2;
        for (int k = 0; k < 10; k++) begin
            tick(k == 0);
            chk(s_oe == 1'b0, "R10 no drive", s_oe, 0);
        end
        chk(flag_out == 2'd2, "R7 flags with tx off", flag_out, 2);
        chk(empty == 1'b0, "R10 empty kept", empty, 0);
        tx_en = 1'b1;
        frame8(24'h3C0000, "R10 word kept");
        chk(underrun == 1'b0, "R10 no underrun", underrun, 0);

        // R6 sync pulse mid-frame, frame not extended and no new transfer
        write_word(24'hA50000);
        tick(1'b1);
        write_word(24'h0F0000);
        for (int k = 1; k < 8; k++) tick(k == 3);
        chk(s_sd == 1'b1, "R6 last bit", s_sd, 1);
        tick(1'b0);
        chk(s_oe == 1'b0, "R6 frame not extended", s_oe, 0);
        chk(empty == 1'b0, "R6 no extra transfer", empty, 0);

        // R4 back-to-back frames
        frame8(24'h0F0000, "R4 frame A");
        write_word(24'hE10000);
        frame8(24'hE10000, "R4 back-to-back B");
        tick(1'b0);
        chk(s_oe == 1'b0, "R4 after B", s_oe, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule